// File: doc/BRIEF.md
# Truth-Table Boolean Logic Unit

This block carries out the sixteen two-operand boolean operations of a 36-bit machine. It has no list of decoded operations. A 4-bit function pattern taken from the opcode is used as a truth table. For every bit position, the accumulator bit and the operand bit together form a 2-bit index, and that index picks one entry of the pattern as the result bit. Setting, complementing, AND, inclusive OR, exclusive OR and equivalence all come out of this one mechanism.

A 2-bit mode field chooses the operand and the destination. The operand is either the memory word or the 18-bit effective address, zero-extended to 36 bits. The destination is the accumulator, memory, or both. The block produces the result word and one write-enable flag for each destination. The memory access itself is done elsewhere. A parameter selects between a purely combinational unit and one with a single output register stage.

Top module: `bool_truth_unit`

## Requirements
- R1: Result bit i equals pattern bit k, where k = 2*acc[i] + operand[i]. The accumulator bit is the high index bit.
- R2: With the accumulator as the first input and the operand as the second, the patterns give these functions: 4'b1000 gives AND, 4'b1110 gives inclusive OR, 4'b0110 gives exclusive OR, 4'b1001 gives equivalence, 4'b0111 gives NAND, and 4'b0010 gives (NOT acc) AND operand.
- R3: Mode 2'b00 (basic) uses the memory word as the operand and raises only the accumulator write flag. The effective address has no effect on the result in this mode.
- R4: Mode 2'b01 (immediate) uses {18'b0, effective address} as the operand and raises only the accumulator write flag.
- R5: Mode 2'b10 (to memory) uses the memory word and raises only the memory write flag. Mode 2'b11 (both) uses the memory word and raises both flags.
- R6: Pattern 4'b0000 gives all zeros and pattern 4'b1111 gives all ones, whatever the operands are.
- R7: With REGISTERED=1 (the default), the result and both flags appear at the first rising clock edge after the inputs are presented and are held until the next edge. While reset is active, the result is zero and both flags are zero.
- R8: Pattern 4'b1100 returns the accumulator, 4'b1010 returns the operand, and 4'b0011 returns the complement of the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_pattern | input | 4 | Truth table; bit k is the result for index k |
| mode | input | 2 | Operand and destination variant |
| acc_val | input | 36 | Accumulator value |
| mem_val | input | 36 | Memory word |
| eff_addr | input | 18 | Effective address, used as the immediate operand |
| result | output | 36 | Boolean result |
| wr_acc | output | 1 | Result is to be written to the accumulator |
| wr_mem | output | 1 | Result is to be written to memory |

## Verification
In the default registered build, the result and both write flags are due one rising edge after new inputs are presented. The bench drives the inputs on a falling edge and samples at the next falling edge, which lies after exactly one rising edge. The bench also samples just after driving new inputs and before the edge, to confirm that the previous result is still being held. The reset value is checked while reset is still active. The bench waits for the internal reset release to complete before it applies any vectors.

// File: rtl/blu_pkg.sv
package blu_pkg;
  typedef enum logic [1:0] {
    MODE_BASIC = 2'b00,
    MODE_IMM   = 2'b01,
    MODE_MEM   = 2'b10,
    MODE_BOTH  = 2'b11
  } blu_mode_e;
endpackage

// File: rtl/blu_operand_sel.sv
module blu_operand_sel import blu_pkg::*; #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 18
) (
  input  blu_mode_e          mode_i,
  input  logic [DATA_W-1:0]  mem_i,
  input  logic [ADDR_W-1:0]  ea_i,
  output logic [DATA_W-1:0]  opnd_o
);
  localparam int PAD_W = DATA_W - ADDR_W;

  // Immediate operand: address in the low half, zeros above
  always_comb begin
    if (mode_i == MODE_IMM) opnd_o = {{PAD_W{1'b0}}, ea_i};
    else                    opnd_o = mem_i;
  end
endmodule

// File: rtl/blu_truth_array.sv
module blu_truth_array #(
  parameter int DATA_W = 36
) (
  input  logic [3:0]         table_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  output logic [DATA_W-1:0]  y_o
);
  // One 4:1 selector per bit; accumulator bit is the high select bit
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic [1:0] sel;
    assign sel    = {a_i[i], b_i[i]};
    assign y_o[i] = table_i[sel];
  end
endmodule

// File: rtl/blu_dest_decode.sv
module blu_dest_decode import blu_pkg::*; (
  input  blu_mode_e mode_i,
  output logic      wr_acc_o,
  output logic      wr_mem_o
);
  always_comb begin
    unique case (mode_i)
      MODE_BASIC: begin wr_acc_o = 1'b1; wr_mem_o = 1'b0; end
      MODE_IMM:   begin wr_acc_o = 1'b1; wr_mem_o = 1'b0; end
      MODE_MEM:   begin wr_acc_o = 1'b0; wr_mem_o = 1'b1; end
      default:    begin wr_acc_o = 1'b1; wr_mem_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/blu_out_stage.sv
module blu_out_stage #(
  parameter int DATA_W     = 36,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] res_i,
  input  logic              wa_i,
  input  logic              wm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wa_o,
  output logic              wm_o
);
  if (REGISTERED) begin : g_reg
    logic [1:0]        rst_sync;
    logic              rst_int_n;
    logic              load_en;
    logic [DATA_W-1:0] res_d, res_q;
    logic              wa_d, wa_q, wm_d, wm_q;

    // Reset is asserted asynchronously and released on a clock edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_sync <= 2'b00;
      else        rst_sync <= {rst_sync[0], 1'b1};
    end
    assign rst_int_n = rst_sync[1];

    always_comb begin
      load_en = rst_int_n;
      res_d   = res_i;
      wa_d    = wa_i;
      wm_d    = wm_i;
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
        res_q <= '0;
        wa_q  <= 1'b0;
        wm_q  <= 1'b0;
      end else if (load_en) begin
        res_q <= res_d;
        wa_q  <= wa_d;
        wm_q  <= wm_d;
      end
    end

    assign res_o = res_q;
    assign wa_o  = wa_q;
    assign wm_o  = wm_q;
  end else begin : g_comb
    assign res_o = res_i;
    assign wa_o  = wa_i;
    assign wm_o  = wm_i;
  end
endmodule

// File: rtl/bool_truth_unit.sv
module bool_truth_unit import blu_pkg::*; #(
  parameter int DATA_W     = 36,
  parameter int ADDR_W     = 18,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        fn_pattern,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] acc_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [ADDR_W-1:0] eff_addr,
  output logic [DATA_W-1:0] result,
  output logic              wr_acc,
  output logic              wr_mem
);
  localparam int PAD_W = DATA_W - ADDR_W;

  blu_mode_e         mode_e;
  logic [DATA_W-1:0] opnd_c;
  logic [DATA_W-1:0] res_c;
  logic              wa_c, wm_c;

  assign mode_e = blu_mode_e'(mode);

  blu_operand_sel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_opnd (
    .mode_i(mode_e), .mem_i(mem_val), .ea_i(eff_addr), .opnd_o(opnd_c)
  );

  blu_truth_array #(.DATA_W(DATA_W)) u_tt (
    .table_i(fn_pattern), .a_i(acc_val), .b_i(opnd_c), .y_o(res_c)
  );

  blu_dest_decode u_dest (
    .mode_i(mode_e), .wr_acc_o(wa_c), .wr_mem_o(wm_c)
  );

  blu_out_stage #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_out (
    .clk(clk), .rst_n(rst_n), .res_i(res_c), .wa_i(wa_c), .wm_i(wm_c),
    .res_o(result), .wa_o(wr_acc), .wm_o(wr_mem)
  );

  AST_XOR_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_pattern == 4'b0110) |-> (res_c == (acc_val ^ opnd_c))); // R2
  AST_AND_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_pattern == 4'b1000) |-> (res_c == (acc_val & opnd_c))); // R2
  AST_IMM_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (opnd_c[DATA_W-1:ADDR_W] == {PAD_W{1'b0}})); // R4
  AST_BASIC_USES_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (opnd_c == mem_val)); // R3
  AST_SOME_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_c || wm_c)); // R5
  AST_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (wm_c && !wa_c)); // R5
  AST_PAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_pattern == 4'b0000) |-> (res_c == '0)); // R6
  AST_PAT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_pattern == 4'b1111) |-> (&res_c)); // R6
endmodule

// File: tb/sim_bool_truth_unit.sv
module sim_bool_truth_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  fn;
    logic [1:0]  md;
    logic [35:0] acc;
    logic [35:0] mem;
    logic [17:0] ea;
    logic [35:0] res;
    logic        wa;
    logic        wm;
  } vec_t;

  localparam int NV = 17;
  localparam logic [35:0] A = 36'hF0F0F0F0F;
  localparam logic [35:0] M = 36'hCCCCCCCCC;
  localparam logic [17:0] E = 18'h35A5A;

  localparam vec_t VECS [NV] = '{
    '{4'b0110, 2'b00, A, M, E, 36'h3C3C3C3C3, 1'b1, 1'b0}, // R2 xor, R3 ea ignored
    '{4'b1000, 2'b00, A, M, E, 36'hC0C0C0C0C, 1'b1, 1'b0}, // R2 and
    '{4'b1110, 2'b00, A, M, E, 36'hFCFCFCFCF, 1'b1, 1'b0}, // R2 ior
    '{4'b1001, 2'b00, A, M, E, 36'hC3C3C3C3C, 1'b1, 1'b0}, // R2 eqv
    '{4'b1100, 2'b00, A, M, E, 36'hF0F0F0F0F, 1'b1, 1'b0}, // R8 acc
    '{4'b1010, 2'b00, A, M, E, 36'hCCCCCCCCC, 1'b1, 1'b0}, // R8 operand
    '{4'b0011, 2'b00, A, M, E, 36'h0F0F0F0F0, 1'b1, 1'b0}, // R8 not acc
    '{4'b0100, 2'b00, A, M, E, 36'h303030303, 1'b1, 1'b0}, // R1 index 2
    '{4'b0111, 2'b00, A, M, E, 36'h3F3F3F3F3, 1'b1, 1'b0}, // R2 nand
    '{4'b0110, 2'b01, A, M, E, 36'hF0F0C5555, 1'b1, 1'b0}, // R4 imm xor
    '{4'b1000, 2'b01, A, M, E, 36'h000030A0A, 1'b1, 1'b0}, // R4 imm and
    '{4'b1110, 2'b10, A, M, E, 36'hFCFCFCFCF, 1'b0, 1'b1}, // R5 to memory
    '{4'b1001, 2'b11, A, M, E, 36'hC3C3C3C3C, 1'b1, 1'b1}, // R5 both
    '{4'b0000, 2'b11, 36'h123456789, 36'hFEDCBA987, 18'h3FFFF, 36'h0, 1'b1, 1'b1}, // R6
    '{4'b1111, 2'b01, A, M, E, 36'hFFFFFFFFF, 1'b1, 1'b0}, // R6
    '{4'b0010, 2'b10, A, M, E, 36'h0C0C0C0C0, 1'b0, 1'b1}, // R1 index 1, R2
    '{4'b1010, 2'b01, A, M, E, 36'h000035A5A, 1'b1, 1'b0}  // R4 zero-extended
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  fn_pattern;
  logic [1:0]  mode;
  logic [35:0] acc_val, mem_val;
  logic [17:0] eff_addr;
  logic [35:0] result;
  logic        wr_acc, wr_mem;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bool_truth_unit u0 (
    .clk(clk), .rst_n(rst_n), .fn_pattern(fn_pattern), .mode(mode),
    .acc_val(acc_val), .mem_val(mem_val), .eff_addr(eff_addr),
    .result(result), .wr_acc(wr_acc), .wr_mem(wr_mem)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    fn_pattern = v.fn;
    mode       = v.md;
    acc_val    = v.acc;
    mem_val    = v.mem;
    eff_addr   = v.ea;
  endtask

  function automatic string mode_tag(input logic [1:0] md);
    if (md == 2'b00)      return "R3";
    else if (md == 2'b01) return "R4";
    else                  return "R5";
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(VECS[2]);
    repeat (3) @(negedge clk);
    // R7: reset holds outputs at zero even with live inputs
    check("R7 reset result", result, 36'h0);
    check("R7 reset flags", {34'h0, wr_acc, wr_mem}, 36'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check("R1 result", result, VECS[i].res);
      check(mode_tag(VECS[i].md), {34'h0, wr_acc, wr_mem}, {34'h0, VECS[i].wa, VECS[i].wm});
    end

    // R3: effective address changes do not affect basic mode
    drive(VECS[0]);
    eff_addr = 18'h00000;
    @(negedge clk);
    check("R3 ea ignored", result, VECS[0].res);

    // R7: new inputs are not visible before the next rising edge
    drive(VECS[11]);
    #1;
    check("R7 hold result", result, VECS[0].res);
    check("R7 hold flags", {34'h0, wr_acc, wr_mem}, 36'h2);
    @(negedge clk);
    check("R7 one-edge latency", result, VECS[11].res);

    // R6: all-ones pattern with all-zero operands
    fn_pattern = 4'b1111; mode = 2'b00; acc_val = '0; mem_val = '0; eff_addr = '0;
    @(negedge clk);
    check("R6 ones with zero operands", result, 36'hFFFFFFFFF);

    // R7: asynchronous reset clears the outputs
    rst_n = 1'b0;
    #1;
    check("R7 async reset", result, 36'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule